// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by counting ticks of a slow time base, given as a one-cycle `tick` strobe in the bus clock domain. If software does not service it in time, it raises a reset request. Software services it by writing a fixed key byte to a service register. An early-warning interrupt fires a programmable number of ticks into the count, so software can still react before the timeout. In window mode, a closed interval comes first. Servicing during that interval counts as a fault, which catches code that services in a tight loop.

All access goes through an 8-bit register port: one write strobe, a 3-bit address, write data, and read data that is combinational from the address. The register map is: 0 control, 1 timing configuration, 2 early-warning offset, 3 interrupt-enable clear, 4 interrupt-enable set, 5 interrupt flag, 6 busy status, 7 service key (reads 0). Control writes and service writes are staged and only take effect on the next tick, which models the slow domain. Busy bits show each staged update until it lands. An always-on setting locks the configuration and keeps the counter running until the next reset.

Top module: `wdog_win`

## Requirements
- R1: After reset, the registers read as follows: address 1 (window code in bits 7:4, period code in bits 3:0) is 0xBB, address 2 is 0x0B, control is 0x00 and busy is 0x00, and `irq` and `rst_req` are 0.
- R2: A period code n selects 8·2^n ticks, and codes 12 to 15 act as code 11. In normal mode, with no servicing, `rst_req` rises on the tick that brings the count to that length.
- R3: Writing 0xA5 to address 7 while the watchdog runs sets busy bit 4 and stages a service. On the next tick the busy bit clears and the count restarts from zero, so a full period of ticks must pass again before a timeout.
- R4: Writing any other byte to address 7 while the watchdog runs sets `rst_req` on the clock edge that takes the write.
- R5: Window mode is control bit 2. In this mode the count first crosses a closed window of 8·2^w ticks, where w is the window code. A service that lands while the count is still below that length sets `rst_req`. A service after that point restarts the count. Without service, the timeout falls at the closed length plus the period length.
- R6: The early-warning flag (address 5, bit 0) is set when the count reaches the window base plus 8·2^e ticks, where e is the low nibble of address 2. The window base is zero in normal mode. Writing 1 to that bit clears the flag and writing 0 does nothing. `irq` equals the flag ANDed with the interrupt enable.
- R7: Writing 1 to bit 0 of address 4 sets the interrupt enable, and writing 1 to bit 0 of address 3 clears it. Writing 0 to either has no effect, and both addresses read back the enable in bit 0.
- R8: The control fields are bit 1 run enable, bit 2 window mode and bit 7 always-on. A control write sets busy bits 1, 2 and 3, and control keeps reading its old value until the next tick, when the new value applies and those busy bits clear.
- R9: Once always-on has applied, the counter runs even with the run enable at 0. Writes to addresses 0, 1 and 2 are then ignored until reset.
- R10: If a staged service lands on the same tick on which the count would reach the timeout, the service wins: no reset request, and the count restarts.
- R11: While neither run enable nor always-on is in force, the count does not advance and writes to address 7 have no effect.
- R12: `rst_req` stays high until `rst_n` is asserted, whatever is written or ticked meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per slow time-base tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | Sticky system reset request |

## Verification
Two functions can act on the same tick: a staged service landing, and the count reaching its timeout. The bench sets up that collision by writing the key after exactly period−1 ticks, so that the service applies on the tick that would expire. It then requires that `rst_req` stays low and that a full fresh period passes before the next timeout. The closed-window edge is probed the same way from both sides: a service after three ticks must fault, and a service after exactly the closed length must restart the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_CODE = 11;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  // closed window plus period, each at most 8<<MAX_CODE, needs MAX_CODE+5 bits
  localparam int CNT_W    = MAX_CODE + 5;
  localparam logic [DATA_W-1:0] SVC_KEY   = 8'hA5;
  localparam logic [DATA_W-1:0] CFG_RESET = 8'hBB;
  localparam logic [CODE_W-1:0] EW_RESET  = 4'hB;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_CFG   = 3'd1,
    A_WARN  = 3'd2,
    A_IECLR = 3'd3,
    A_IESET = 3'd4,
    A_FLAG  = 3'd5,
    A_BUSY  = 3'd6,
    A_KICK  = 3'd7
  } reg_addr_e;

  // Tick count selected by a 4-bit code; reserved codes saturate.
  function automatic logic [CNT_W-1:0] code_ticks(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] s;
    s = (int'(c) > MAX_CODE) ? CODE_W'(MAX_CODE) : c;
    return CNT_W'(8) << s;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic              win,
  output logic              aon,
  output logic              running,
  output logic [DATA_W-1:0] cfg_byte,
  output logic [CODE_W-1:0] ew_code,
  output logic              busy_ctrl,
  output logic              busy_kick,
  output logic              svc_apply,
  output logic              key_bad
);
  logic              en_q, win_q, aon_q;
  logic [2:0]        pend_q;      // {aon, win, en}
  logic              busy_ctrl_q, kick_pend_q;
  logic [DATA_W-1:0] cfg_q;
  logic [CODE_W-1:0] ew_q;

  // named events
  logic lock, ctrl_wr, cfg_wr, warn_wr, kick_wr, kick_ok, ctrl_apply;
  assign lock       = aon_q | (busy_ctrl_q & pend_q[2]);
  assign ctrl_wr    = wr_en && (addr == A_CTRL) && !lock;
  assign cfg_wr     = wr_en && (addr == A_CFG)  && !aon_q;
  assign warn_wr    = wr_en && (addr == A_WARN) && !aon_q;
  assign running    = en_q | aon_q;
  assign kick_wr    = wr_en && (addr == A_KICK) && running;
  assign kick_ok    = kick_wr && (wdata == SVC_KEY);
  assign key_bad    = kick_wr && (wdata != SVC_KEY);
  assign ctrl_apply = tick && busy_ctrl_q;
  assign svc_apply  = tick && kick_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      win_q       <= 1'b0;
      aon_q       <= 1'b0;
      pend_q      <= '0;
      busy_ctrl_q <= 1'b0;
      kick_pend_q <= 1'b0;
      cfg_q       <= CFG_RESET;
      ew_q        <= EW_RESET;
    end else begin
      if (ctrl_apply) begin
        en_q        <= pend_q[0];
        win_q       <= pend_q[1];
        aon_q       <= aon_q | pend_q[2];
        busy_ctrl_q <= 1'b0;
      end
      if (tick) kick_pend_q <= 1'b0;
      if (ctrl_wr) begin
        pend_q      <= {wdata[7], wdata[2], wdata[1]};
        busy_ctrl_q <= 1'b1;
      end
      if (cfg_wr)  cfg_q <= wdata;
      if (warn_wr) ew_q  <= wdata[CODE_W-1:0];
      if (kick_ok) kick_pend_q <= 1'b1;
    end
  end

  assign en        = en_q;
  assign win       = win_q;
  assign aon       = aon_q;
  assign cfg_byte  = cfg_q;
  assign ew_code   = ew_q;
  assign busy_ctrl = busy_ctrl_q;
  assign busy_kick = kick_pend_q;

  // R9: always-on freezes the control and configuration state
  p_aon_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aon_q |=> aon_q && $stable(en_q) && $stable(win_q) && $stable(cfg_q) && $stable(ew_q));
  // R8: a staged control update is gone after the tick that applies it
  p_ctrl_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_apply && !ctrl_wr) |=> !busy_ctrl_q);
  // R3: a staged service is gone after the tick that applies it
  p_kick_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_apply && !kick_ok) |=> !kick_pend_q);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              running,
  input  logic              win,
  input  logic [CODE_W-1:0] per_code,
  input  logic [CODE_W-1:0] win_code,
  input  logic [CODE_W-1:0] ew_code,
  input  logic              svc_apply,
  input  logic              key_bad,
  output logic              ew_hit,
  output logic              rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, closed_len, limit, ew_at;
  logic             rst_q;
  logic             step, early_fault, restart, expire;

  assign closed_len  = win ? code_ticks(win_code) : '0;
  assign limit       = closed_len + code_ticks(per_code);
  assign ew_at       = closed_len + code_ticks(ew_code);
  assign cnt_nxt     = cnt_q + 1'b1;

  assign step        = tick && running && !rst_q;
  assign early_fault = step && svc_apply && win && (cnt_q < closed_len);
  assign restart     = step && svc_apply && !early_fault;
  assign expire      = step && !svc_apply && (cnt_nxt >= limit);
  assign ew_hit      = step && !svc_apply && (cnt_nxt == ew_at);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (!running)     cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_nxt;
      rst_q <= rst_q | expire | early_fault | key_bad;
    end
  end

  assign rst_req = rst_q;

  // R12: the request never drops without reset
  p_rst_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  // R4: a wrong key requests reset on the next edge
  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> rst_q);
  // R5: a closed-window service requests reset
  p_early_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    early_fault |=> rst_q);
  // R10: a landing service never raises the request itself
  p_svc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !key_bad) |=> (rst_q == $past(rst_q)));
  // R11: an idle watchdog cannot raise a request
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !rst_q) |=> !rst_q);
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ew_hit,
  output logic              ie,
  output logic              flag,
  output logic              irq
);
  logic ie_q, flag_q;
  logic ie_set, ie_clr, flag_clr;

  assign ie_set   = wr_en && (addr == A_IESET) && wdata[0];
  assign ie_clr   = wr_en && (addr == A_IECLR) && wdata[0];
  assign flag_clr = wr_en && (addr == A_FLAG)  && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ie_set)      ie_q <= 1'b1;
      else if (ie_clr) ie_q <= 1'b0;
      if (ew_hit)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign ie   = ie_q;
  assign flag = flag_q;
  assign irq  = flag_q & ie_q;

  // R6: an early-warning event always leaves the flag set
  p_ew_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ew_hit |=> flag_q);
  // R7: a write of zero leaves the enable unchanged
  p_ie_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[0]) |=> $stable(ie_q));
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  logic              en, win, aon, running, busy_ctrl, busy_kick;
  logic              svc_apply, key_bad, ew_hit, ie, flag;
  logic [DATA_W-1:0] cfg_byte;
  logic [CODE_W-1:0] ew_code;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .en(en), .win(win), .aon(aon), .running(running),
    .cfg_byte(cfg_byte), .ew_code(ew_code), .busy_ctrl(busy_ctrl),
    .busy_kick(busy_kick), .svc_apply(svc_apply), .key_bad(key_bad)
  );

  wdog_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(running), .win(win),
    .per_code(cfg_byte[CODE_W-1:0]), .win_code(cfg_byte[DATA_W-1:CODE_W]),
    .ew_code(ew_code), .svc_apply(svc_apply), .key_bad(key_bad),
    .ew_hit(ew_hit), .rst_req(rst_req)
  );

  wdog_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ew_hit(ew_hit), .ie(ie), .flag(flag), .irq(irq)
  );

  always_comb begin
    unique case (addr)
      A_CTRL:          rdata = {aon, 4'b0000, win, en, 1'b0};
      A_CFG:           rdata = cfg_byte;
      A_WARN:          rdata = {{(DATA_W-CODE_W){1'b0}}, ew_code};
      A_IECLR, A_IESET: rdata = {{(DATA_W-1){1'b0}}, ie};
      A_FLAG:          rdata = {{(DATA_W-1){1'b0}}, flag};
      A_BUSY:          rdata = {3'b000, busy_kick, busy_ctrl, busy_ctrl, busy_ctrl, 1'b0};
      default:         rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_wdog_win.sv
`timescale 1ns/1ps
module sim_wdog_win;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, rst_req;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  wdog_win u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
               .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  // reset, program config, write control and let it apply
  task automatic setup(input logic [7:0] cfg, input logic [7:0] ctl);
    do_reset();
    wr(3'd1, cfg);
    wr(3'd0, ctl);
    ticks(1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(3'd1, d); chk("R1 cfg", d, 8'hBB);
    rd(3'd2, d); chk("R1 warn", d, 8'h0B);
    rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(3'd6, d); chk("R1 busy", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_period();
    setup(8'h01, 8'h02);             // 16 ticks
    ticks(15); chk("R2 before 16", rst_req, 0);
    ticks(1);  chk("R2 at 16", rst_req, 1);
    setup(8'h0F, 8'h02);             // reserved code acts as 16384
    ticks(16383); chk("R2 code15 before", rst_req, 0);
    ticks(1);     chk("R2 code15 at", rst_req, 1);
    ticks(3); wr(3'd7, 8'hA5);
    chk("R12 sticky", rst_req, 1);
  endtask

  task automatic t_service();
    logic [7:0] d;
    setup(8'h00, 8'h02);             // 8 ticks
    ticks(5);
    wr(3'd7, 8'hA5);
    rd(3'd6, d); chk("R3 busy kick", d, 8'h10);
    ticks(1);
    rd(3'd6, d); chk("R3 busy clear", d, 8'h00);
    ticks(7); chk("R3 after restart", rst_req, 0);
    ticks(1); chk("R3 full period", rst_req, 1);
  endtask

  task automatic t_badkey();
    setup(8'h00, 8'h02);
    wr(3'd7, 8'h5A);
    chk("R4 bad key", rst_req, 1);
    do_reset();
    chk("R12 cleared by reset", rst_req, 0);
  endtask

  task automatic t_window();
    setup(8'h00, 8'h06);             // closed 8, open 8
    ticks(3); wr(3'd7, 8'hA5); ticks(1);
    chk("R5 closed service", rst_req, 1);
    setup(8'h00, 8'h06);
    ticks(8); wr(3'd7, 8'hA5); ticks(1);
    chk("R5 open service", rst_req, 0);
    ticks(15); chk("R5 before W+P", rst_req, 0);
    ticks(1);  chk("R5 at W+P", rst_req, 1);
  endtask

  task automatic t_warn();
    logic [7:0] d;
    do_reset();
    wr(3'd1, 8'h02);                 // period 32
    wr(3'd2, 8'h00);                 // warning at 8
    wr(3'd4, 8'h01);
    rd(3'd3, d); chk("R7 set reads back", d, 8'h01);
    wr(3'd0, 8'h02); ticks(1);
    ticks(7); chk("R6 irq early", irq, 0);
    ticks(1); chk("R6 irq at offset", irq, 1);
    rd(3'd5, d); chk("R6 flag", d, 8'h01);
    wr(3'd5, 8'h00); rd(3'd5, d); chk("R6 zero write", d, 8'h01);
    wr(3'd5, 8'h01); rd(3'd5, d); chk("R6 flag cleared", d, 8'h00);
    chk("R6 irq off", irq, 0);
    wr(3'd3, 8'h00); rd(3'd4, d); chk("R7 zero clear", d, 8'h01);
    wr(3'd3, 8'h01); rd(3'd4, d); chk("R7 cleared", d, 8'h00);
    chk("R6 no early reset", rst_req, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h06);
    rd(3'd6, d); chk("R8 busy", d, 8'h0E);
    rd(3'd0, d); chk("R8 old value", d, 8'h00);
    ticks(1);
    rd(3'd6, d); chk("R8 busy done", d, 8'h00);
    rd(3'd0, d); chk("R8 applied", d, 8'h06);
  endtask

  task automatic t_aon();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h80); ticks(1);
    rd(3'd0, d); chk("R9 aon set", d, 8'h80);
    wr(3'd0, 8'h00);
    rd(3'd6, d); chk("R9 ctrl blocked busy", d, 8'h00);
    rd(3'd0, d); chk("R9 ctrl kept", d, 8'h80);
    wr(3'd1, 8'h00); rd(3'd1, d); chk("R9 cfg kept", d, 8'hBB);
    wr(3'd2, 8'h03); rd(3'd2, d); chk("R9 warn kept", d, 8'h0B);
    wr(3'd7, 8'h00); chk("R9 runs forced", rst_req, 1);
  endtask

  task automatic t_collide();
    setup(8'h00, 8'h02);
    ticks(7); wr(3'd7, 8'hA5);
    ticks(1); chk("R10 service beats timeout", rst_req, 0);
    ticks(7); chk("R10 restarted", rst_req, 0);
    ticks(1); chk("R10 next timeout", rst_req, 1);
  endtask

  task automatic t_idle();
    logic [7:0] d;
    do_reset();
    wr(3'd1, 8'h00);
    wr(3'd7, 8'h33); chk("R11 key ignored", rst_req, 0);
    wr(3'd7, 8'hA5);
    rd(3'd6, d); chk("R11 no busy", d, 8'h00);
    ticks(20); chk("R11 no count", rst_req, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_service();
    t_badkey();
    t_window();
    t_warn();
    t_ctrl();
    t_aon();
    t_collide();
    t_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule